// File: doc/BRIEF.md
# Asynchronous Byte-Load Configuration Port

This block lets a host processor push a configuration stream into a device one byte at a time. The host puts a byte on an 8-bit data bus, raises both chip selects and pulses a write strobe. When the strobe is released, the block takes the byte that was on the bus, drops its ready line and sends the byte out one bit per clock period on a serial output. The serial output changes on the falling edge of the configuration clock. When all eight bits have gone out, ready rises again and the host may write the next byte at once.

All host inputs are asynchronous to the configuration clock, so they pass through a two-stage synchronizer before the strobe edge is detected. The host can also poll for readiness without watching the ready pin. A read strobe, qualified by both chip selects, enables a driver for the top bit of the data bus, and that bit then carries the ready status. The block presents this as a data value plus an output enable for the pad. The lower seven bits are never driven.

A write whose strobe release is detected while a byte is still shifting is dropped and sets a sticky error flag. Only a reset clears that flag.

Top module: `cfg_byte_loader`

## Requirements
- R1: A write takes effect only when `cs_a`, `cs_b` and `wr_en` are all high at the same time. A strobe given with only one chip select high leaves `ready`, `dout` and `err` unchanged.
- R2: The byte that is loaded is the value `wdata` held during the last synchronized cycle before the qualified strobe was released. Changes to `wdata` earlier in the same strobe do not matter.
- R3: After a byte is accepted, `ready` is low for exactly 8 configuration clock periods and then returns high. `ready` falls at the third rising edge after the release of `wr_en`.
- R4: `dout` sends the accepted byte least significant bit first, one bit per clock period. Each bit is updated on a falling clock edge, and bit k appears on the k-th falling edge after `ready` falls (counting from 0).
- R5: Once a byte has been fully sent, `dout` keeps the last bit sent (byte bit 7) until the next byte starts shifting.
- R6: While `rd_en`, `cs_a` and `cs_b` are all high, `stat_oe` is 1 and `stat_d7` equals `ready`. In every other case `stat_oe` is 0, and this follows the inputs with no clock delay.
- R7: A qualified write whose release is detected while a byte is still shifting is ignored. It does not change the bits being sent and starts no new shift. `err` goes to 1 and stays 1 until reset.
- R8: A new write may begin in the first cycle after `ready` is seen high. It is accepted with the same 3-edge latency as any other write.
- R9: While `rst_n` is low at a clock edge, `ready` becomes 1, `err` becomes 0 and `dout` becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_a | input | 1 | First chip select, active high, asynchronous |
| cs_b | input | 1 | Second chip select, active high, asynchronous |
| wr_en | input | 1 | Write strobe, active high; the byte is taken at its release |
| rd_en | input | 1 | Status read strobe, active high |
| wdata | input | 8 | Host data byte |
| ready | output | 1 | High when a new byte may be written |
| dout | output | 1 | Serial data out, LSB first, updated on the falling clock edge |
| stat_d7 | output | 1 | Ready status value for data bit 7 |
| stat_oe | output | 1 | Output enable for the data bit 7 driver |
| err | output | 1 | Sticky flag: a write arrived while busy |

## Verification
The serializer is driven with a table of bytes: alternating patterns, a single low bit, a single high bit, all ones, all zeros and a nibble pattern. Together these show whether the bit order is reversed, a bit is lost, or the output is stuck. The table writes run back to back, so a ready line held too long or too short shows up as a wrong acceptance latency on the next byte. Directed cases cover:
- a strobe with only one chip select, which must not be taken as a write;
- data that changes while the strobe is held, which tells end-of-strobe capture apart from start-of-strobe capture;
- a write and a status read issued in the middle of a shift, which tells a dropped write apart from one that corrupts or restarts the serializer.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int unsigned CFGL_BYTE_W = 8;
  localparam int unsigned CFGL_SYNC_STAGES = 2;

  // A host write is qualified only when both selects and the strobe are high together.
  function automatic logic host_write_qual(input logic sel_a, input logic sel_b, input logic strobe);
    return sel_a & sel_b & strobe;
  endfunction

  // Index of the last bit slot in a shift window of the given width.
  function automatic int unsigned last_slot(input int unsigned width);
    return width - 1;
  endfunction
endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int unsigned WIDTH  = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cfgl_capture.sv
module cfgl_capture #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual,
  input  logic [BYTE_W-1:0] data_s,
  input  logic              busy,
  output logic              write_done,
  output logic              load,
  output logic [BYTE_W-1:0] byte_q,
  output logic              err
);
  logic qual_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qual_d <= 1'b0;
      byte_q <= '0;
      err    <= 1'b0;
    end else begin
      qual_d <= qual;
      if (qual) byte_q <= data_s;
      if (write_done && busy) err <= 1'b1;
    end
  end

  // End of a qualified strobe, seen in the clock domain
  assign write_done = qual_d & ~qual;
  assign load       = write_done & ~busy;

  // R7
  ignore_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (write_done && busy) |=> err);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/cfgl_serializer.sv
module cfgl_serializer #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              busy,
  output logic              dout
);
  import cfgl_pkg::*;

  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(last_slot(BYTE_W));

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      slot  <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= load_byte;
      slot  <= '0;
      busy  <= 1'b1;
    end else if (busy) begin
      shreg <= shreg >> 1;
      slot  <= slot + 1'b1;
      if (slot == LAST) busy <= 1'b0;
    end
  end

  // Serial output is retimed onto the falling edge; holds the tail while idle.
  always_ff @(negedge clk) begin
    if (!rst_n)    dout <= 1'b0;
    else if (busy) dout <= shreg[0];
  end

  // Independent run-length watch on busy for the window bound
  logic [CNT_W:0] busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  // R3
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= (CNT_W+1)'(BYTE_W));
  // R3
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader #(
  parameter int unsigned BYTE_W      = cfgl_pkg::CFGL_BYTE_W,
  parameter int unsigned SYNC_STAGES = cfgl_pkg::CFGL_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic              ready,
  output logic              dout,
  output logic              stat_d7,
  output logic              stat_oe,
  output logic              err
);
  import cfgl_pkg::*;

  localparam int unsigned SYNC_W = BYTE_W + 3;

  logic [SYNC_W-1:0] sync_q;
  logic              cs_a_s, cs_b_s, wr_s;
  logic [BYTE_W-1:0] data_s;
  logic              qual;
  logic              write_done, load, busy;
  logic [BYTE_W-1:0] byte_q;

  cfgl_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({wdata, cs_a, cs_b, wr_en}),
    .sync_out (sync_q)
  );

  assign {data_s, cs_a_s, cs_b_s, wr_s} = sync_q;
  assign qual = host_write_qual(cs_a_s, cs_b_s, wr_s);

  cfgl_capture #(.BYTE_W(BYTE_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .qual       (qual),
    .data_s     (data_s),
    .busy       (busy),
    .write_done (write_done),
    .load       (load),
    .byte_q     (byte_q),
    .err        (err)
  );

  cfgl_serializer #(.BYTE_W(BYTE_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_byte (byte_q),
    .busy      (busy),
    .dout      (dout)
  );

  assign ready   = ~busy;
  // Status path is combinational from the host pins so the pad releases at once.
  assign stat_oe = host_write_qual(cs_a, cs_b, rd_en);
  assign stat_d7 = ready;

  // R3
  accept_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ready);
endmodule

// File: tb/cfg_byte_loader_tb.sv
module cfg_byte_loader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_a, cs_b, wr_en, rd_en;
  logic [7:0] wdata;
  logic       ready, dout, stat_d7, stat_oe, err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cfg_byte_loader dut_i (
    .clk(clk), .rst_n(rst_n), .cs_a(cs_a), .cs_b(cs_b), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .ready(ready), .dout(dout),
    .stat_d7(stat_d7), .stat_oe(stat_oe), .err(err)
  );

  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h01, 8'hFE, 8'hFF, 8'h00, 8'h3C};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive a strobe for three cycles; the last cycle carries b_last.
  task automatic host_write(input logic [7:0] b_first, input logic [7:0] b_last,
                            input logic sa, input logic sb);
    @(negedge clk);
    wdata = b_first; cs_a = sa; cs_b = sb; wr_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wdata = b_last;
    @(negedge clk);
    wr_en = 1'b0; cs_a = 1'b0; cs_b = 1'b0;
  endtask

  task automatic wait_accept(output int edges);
    edges = 99;
    for (int n = 1; n <= 8; n++) begin
      @(posedge clk); #2;
      if (!ready) begin
        edges = n;
        return;
      end
    end
  endtask

  // Follows the eight serial slots; optionally injects a write and a status read.
  task automatic follow_shift(input logic [7:0] b, input bit inject);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #2;
      check(dout == b[k], $sformatf("R4 R2 bit %0d of %0h", k, b), dout, b[k]);
      check(!ready, "R3 ready low inside window", ready, 0);
      if (inject && k == 0) begin
        wdata = 8'h00; cs_a = 1'b1; cs_b = 1'b1; wr_en = 1'b1;
      end
      if (inject && k == 2) begin
        wr_en = 1'b0; cs_a = 1'b0; cs_b = 1'b0;
      end
      if (inject && k == 4) begin
        rd_en = 1'b1; cs_a = 1'b1; cs_b = 1'b1; #1;
        check(stat_oe == 1'b1, "R6 oe during read", stat_oe, 1);
        check(stat_d7 == 1'b0, "R6 status busy", stat_d7, 0);
        rd_en = 1'b0; #1;
        check(stat_oe == 1'b0, "R6 oe released", stat_oe, 0);
        cs_a = 1'b0; cs_b = 1'b0;
      end
    end
    @(posedge clk); #2;
    check(ready == 1'b1, "R3 ready high after 8 periods", ready, 1);
  endtask

  task automatic quiet_watch(input string req, input logic tail);
    int lows = 0;
    for (int n = 0; n < 10; n++) begin
      @(posedge clk); #2;
      if (!ready) lows++;
    end
    check(lows == 0, {req, " no shift started"}, lows, 0);
    check(dout == tail, {req, " dout unchanged"}, dout, tail);
  endtask

  initial begin
    int e;
    rst_n = 1'b0; cs_a = 0; cs_b = 0; wr_en = 0; rd_en = 0; wdata = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    check(ready == 1'b1, "R9 reset ready", ready, 1);
    check(err == 1'b0, "R9 reset err", err, 0);
    check(dout == 1'b0, "R9 reset dout", dout, 0);
    check(stat_oe == 1'b0, "R6 idle oe", stat_oe, 0);
    @(negedge clk); rst_n = 1'b1;

    // R6: read with one select only, then a qualified idle read
    rd_en = 1'b1; cs_a = 1'b1; #1;
    check(stat_oe == 1'b0, "R6 oe with one select", stat_oe, 0);
    cs_b = 1'b1; #1;
    check(stat_oe == 1'b1 && stat_d7 == 1'b1, "R6 idle status", {stat_oe, stat_d7}, 3);
    rd_en = 1'b0; cs_a = 1'b0; cs_b = 1'b0;

    // R1: strobe with only one select each way
    host_write(8'h5A, 8'h5A, 1'b1, 1'b0);
    quiet_watch("R1 cs_a only", 1'b0);
    host_write(8'h5A, 8'h5A, 1'b0, 1'b1);
    quiet_watch("R1 cs_b only", 1'b0);
    check(err == 1'b0, "R1 err untouched", err, 0);

    // Table of bytes, back to back (R8)
    for (int i = 0; i < NVEC; i++) begin
      host_write(VEC[i], VEC[i], 1'b1, 1'b1);
      wait_accept(e);
      check(e == 3, $sformatf("R8 R3 accept latency byte %0d", i), e, 3);
      follow_shift(VEC[i], 1'b0);
    end

    // R5: tail held after last byte
    for (int n = 0; n < 4; n++) begin
      @(negedge clk); #2;
      check(dout == VEC[NVEC-1][7], "R5 tail held", dout, VEC[NVEC-1][7]);
    end

    // R2: data changes while strobe held; last value is captured
    host_write(8'h11, 8'hC3, 1'b1, 1'b1);
    wait_accept(e);
    check(e == 3, "R2 accept latency", e, 3);
    follow_shift(8'hC3, 1'b0);

    // R7: write during shift ignored, err sticky; R6 mid-shift read
    host_write(8'h96, 8'h96, 1'b1, 1'b1);
    wait_accept(e);
    check(e == 3, "R7 accept latency", e, 3);
    check(err == 1'b0, "R7 err clear before", err, 0);
    follow_shift(8'h96, 1'b1);
    check(err == 1'b1, "R7 err set", err, 1);
    quiet_watch("R7 ignored write", 1'b1);
    check(err == 1'b1, "R7 err sticky", err, 1);

    // R9: reset clears err and dout
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #2;
    @(negedge clk); #2;
    check(err == 1'b0, "R9 err cleared", err, 0);
    check(ready == 1'b1, "R9 ready after reset", ready, 1);
    check(dout == 1'b0, "R9 dout cleared", dout, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule